// File: doc/BRIEF.md
# Receive Buffer Space Manager

This block keeps track of the memory area into which incoming frames are placed. It holds a 32-bit buffer address and a 32-bit count of remaining 16-bit words, both loaded from a circular table of four-word entries in memory. For each frame presented by the receive path, the block rounds the stored length (frame bytes plus a 4-byte checksum) up to the bus granule. It checks that the rounded length fits in the remaining space. If it fits, it grants the write at the current address and moves the address and the count past the frame.

When the space runs low, or a frame does not fit, the buffer is treated as finished. The block then reads the next table entry through a simple one-request-at-a-time memory read port. If the host has not supplied any further entries, it enters a blocked state and drops frames until the host adds entries and orders a fetch. The table read pointer wraps from the end bound back to the start bound. An interrupt pulse reports when that pointer catches up with the host's write pointer.

A host-side controller drives the table bounds, the write pointer, pointer loads and fetch commands. The frame-data mover uses `store_ok`, `store_addr` and `store_len` to place the frame and its padding.

Top module: `rx_buf_rsrc_mgr`

## Requirements
- R1: The stored length is `frm_len + 4`. It is rounded up to a multiple of 4 bytes when `wide_mode` is 1 and to a multiple of 2 bytes when it is 0. The rounded value is reported on `store_len` together with `store_ok`.
- R2: A frame is stored only if its rounded length is at most twice `words_left`; equality fits. Otherwise `irq_area_exceeded` pulses for one cycle, `store_ok` stays low, and address and count are unchanged.
- R3: One cycle after an accepted frame's `frm_valid`, `store_ok` is high and `store_addr` holds the previous `buf_addr`. In the same cycle `buf_addr` has grown by the rounded length and `words_left` has shrunk by half of it.
- R4: A fetch issues exactly four single-cycle read requests at `rd_ptr + k*S` for k = 0..3, where S is 2 in narrow mode and 4 in wide mode. The returned words load, in that order: address bits 15:0, address bits 31:16, count bits 15:0, count bits 31:16.
- R5: At the end of a fetch, `rd_ptr` advances by 4*S. If the result equals `tbl_end`, it becomes `tbl_start`.
- R6: If the pointer after R5 equals `tbl_wr`, `irq_exhausted` pulses once.
- R7: A frame is the last one for the current buffer in either of two cases: it was refused under R2, or after storing it `words_left` is below `eob_words`. After a last frame, the block sets `blocked` if `rd_ptr` equals `tbl_wr`; otherwise it starts a fetch on its own (`busy` high in the next cycle).
- R8: While `blocked` is high, frames are dropped with a `frm_drop` pulse and change nothing. A completed fetch, started by `fetch_cmd`, clears `blocked`.
- R9: `seq` starts at 0. Its low byte increments once per stored frame and wraps modulo 256 without touching the high byte.
- R10: A frame presented while a fetch is in progress (`busy` high) is dropped with `frm_drop` and leaves address and count unchanged.
- R11: After reset, `buf_addr`, `words_left`, `rd_ptr` and `seq` are 0, and `blocked` and `busy` are low.
- R12: `ptr_load` (taken only while idle) sets `rd_ptr` to `ptr_val` with bit 0 cleared in narrow mode and bits 1:0 cleared in wide mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1: 32-bit bus granule, 0: 16-bit granule |
| tbl_start | input | PTR_W | Table start bound (byte address) |
| tbl_end | input | PTR_W | Table end bound, exclusive |
| tbl_wr | input | PTR_W | Host write pointer into the table |
| ptr_load | input | 1 | Load `rd_ptr` from `ptr_val` |
| ptr_val | input | PTR_W | Value for `rd_ptr` |
| fetch_cmd | input | 1 | Host request to fetch the next entry |
| eob_words | input | CNT_W | Low-space threshold in words |
| frm_valid | input | 1 | Frame length present (one cycle) |
| frm_len | input | LEN_W | Frame length in bytes, checksum excluded |
| mem_rd_req | output | 1 | Table read request (one cycle) |
| mem_rd_addr | output | PTR_W | Table read address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | DATA_W | Read data |
| buf_addr | output | 2*DATA_W | Current buffer address |
| words_left | output | CNT_W | Remaining words in buffer |
| rd_ptr | output | PTR_W | Table read pointer |
| store_ok | output | 1 | Frame granted for storing |
| store_addr | output | 2*DATA_W | Start address of granted frame |
| store_len | output | LEN_W+2 | Rounded stored length in bytes |
| frm_drop | output | 1 | Frame dropped (blocked or busy) |
| irq_area_exceeded | output | 1 | Frame too large for remaining space |
| irq_exhausted | output | 1 | Read pointer reached write pointer |
| blocked | output | 1 | Reception held until host adds entries |
| busy | output | 1 | Table fetch in progress |
| seq | output | SEQ_W | Frame sequence counter |

## Verification
The assertions check on every cycle the properties that hold at all times. The outcome pulses are mutually exclusive, and no grant appears while blocked or while a fetch is running. Stored lengths are even, and a refused frame always leads to either blocking or a fetch. Read requests last a single cycle, and the pointer never rests on the end bound. The sequence high byte never moves, and the count never grows on a store. The exact rounding values, the four read addresses and their load order, and the wrap onto the start bound can only be shown by the bench scenarios. The same holds for the exhaustion pulse, the low-space threshold decision, the release from the blocked state and the modulo-256 sequence wrap. The bench sweeps frame lengths in both modes against arithmetic it computes itself.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_REQ  = 2'd1,
      FS_WAIT = 2'd2
   } fetch_st_t;

   localparam int ENTRY_WORDS = 4;
endpackage

// File: rtl/rbm_len_calc.sv
module rbm_len_calc #(
   parameter int LEN_W = 16,
   parameter int CNT_W = 32,
   localparam int PL_W = LEN_W + 2
) (
   input  logic [LEN_W-1:0] frm_len,
   input  logic             wide,
   input  logic [CNT_W-1:0] words_left,
   output logic [PL_W-1:0]  padded,
   output logic             fits
);
   logic [PL_W-1:0]  raw_len;
   logic [PL_W-1:0]  up4;
   logic [PL_W-1:0]  up2;
   logic [CNT_W:0]   room_bytes;
   logic [CNT_W:0]   need_bytes;

   // frame bytes plus the 4-byte checksum
   assign raw_len = {2'b00, frm_len} + PL_W'(4);
   assign up4     = (raw_len + PL_W'(3)) & {{(PL_W-2){1'b1}}, 2'b00};
   assign up2     = (raw_len + PL_W'(1)) & {{(PL_W-1){1'b1}}, 1'b0};
   assign padded  = wide ? up4 : up2;

   assign room_bytes = {words_left, 1'b0};
   assign need_bytes = (CNT_W+1)'(padded);
   assign fits       = (need_bytes <= room_bytes);
endmodule

// File: rtl/rbm_account.sv
module rbm_account #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 32,
   parameter int PL_W   = 18,
   parameter int SEQ_W  = 16,
   localparam int ADDR_W = 2 * DATA_W,
   localparam int HALF   = SEQ_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [1:0]        ld_idx,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              take,
   input  logic [PL_W-1:0]   padded,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [CNT_W-1:0]  words_left,
   output logic [SEQ_W-1:0]  seq
);
   logic [CNT_W-1:0] used_words;

   assign used_words = CNT_W'(padded >> 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_addr   <= '0;
         words_left <= '0;
         seq        <= '0;
      end else if (ld_valid) begin
         case (ld_idx)
            2'd0:    buf_addr[DATA_W-1:0]          <= ld_data;
            2'd1:    buf_addr[ADDR_W-1:DATA_W]     <= ld_data;
            2'd2:    words_left[DATA_W-1:0]        <= ld_data;
            default: words_left[CNT_W-1:DATA_W]    <= ld_data;
         endcase
      end else if (take) begin
         buf_addr   <= buf_addr + ADDR_W'(padded);
         words_left <= words_left - used_words;
         seq        <= {seq[SEQ_W-1:HALF], seq[HALF-1:0] + 1'b1};
      end
   end

   AST_COUNT_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (words_left <= $past(words_left)));   // R3
   AST_SEQ_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(seq[SEQ_W-1:HALF]));   // R9
endmodule

// File: rtl/rbm_fetch.sv
module rbm_fetch
   import rbm_pkg::*;
#(
   parameter int PTR_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wide,
   input  logic              ptr_load,
   input  logic [PTR_W-1:0]  ptr_val,
   input  logic [PTR_W-1:0]  tbl_start,
   input  logic [PTR_W-1:0]  tbl_end,
   input  logic [PTR_W-1:0]  tbl_wr,
   output logic              mem_rd_req,
   output logic [PTR_W-1:0]  mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              ld_valid,
   output logic [1:0]        ld_idx,
   output logic [DATA_W-1:0] ld_data,
   output logic              done,
   output logic              busy,
   output logic [PTR_W-1:0]  rd_ptr,
   output logic              exhausted
);
   fetch_st_t        state;
   logic [1:0]       idx;
   logic [PTR_W-1:0] offs;
   logic [PTR_W-1:0] entry_bytes;
   logic [PTR_W-1:0] ptr_raw;
   logic [PTR_W-1:0] ptr_next;
   logic [PTR_W-1:0] align_mask;

   assign offs        = wide ? PTR_W'({idx, 2'b00}) : PTR_W'({idx, 1'b0});
   assign entry_bytes = wide ? PTR_W'(ENTRY_WORDS * 4) : PTR_W'(ENTRY_WORDS * 2);
   assign ptr_raw     = rd_ptr + entry_bytes;
   assign ptr_next    = (ptr_raw == tbl_end) ? tbl_start : ptr_raw;
   assign align_mask  = wide ? ~PTR_W'(3) : ~PTR_W'(1);

   assign busy        = (state != FS_IDLE);
   assign mem_rd_req  = (state == FS_REQ);
   assign mem_rd_addr = rd_ptr + offs;
   assign ld_valid    = (state == FS_WAIT) && mem_rd_valid;
   assign ld_idx      = idx;
   assign ld_data     = mem_rd_data;
   assign done        = ld_valid && (idx == 2'd3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= FS_IDLE;
         idx       <= 2'd0;
         rd_ptr    <= '0;
         exhausted <= 1'b0;
      end else begin
         exhausted <= 1'b0;
         case (state)
            FS_IDLE: begin
               if (start) begin
                  state <= FS_REQ;
                  idx   <= 2'd0;
               end else if (ptr_load) begin
                  rd_ptr <= ptr_val & align_mask;
               end
            end
            FS_REQ: state <= FS_WAIT;
            FS_WAIT: begin
               if (mem_rd_valid) begin
                  if (idx == 2'd3) begin
                     state     <= FS_IDLE;
                     rd_ptr    <= ptr_next;
                     exhausted <= (ptr_next == tbl_wr);
                  end else begin
                     idx   <= idx + 2'd1;
                     state <= FS_REQ;
                  end
               end
            end
            default: state <= FS_IDLE;
         endcase
      end
   end

   AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |=> !mem_rd_req);   // R4
   AST_PTR_OFF_END: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ((rd_ptr != $past(tbl_end)) || ($past(tbl_start) == $past(tbl_end))));   // R5
   AST_EXH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      exhausted |-> (rd_ptr == $past(tbl_wr)));   // R6
endmodule

// File: rtl/rx_buf_rsrc_mgr.sv
module rx_buf_rsrc_mgr #(
   parameter int DATA_W       = 16,
   parameter int LEN_W        = 16,
   parameter int CNT_W        = 32,
   parameter int PTR_W        = 16,
   parameter int SEQ_W        = 16,
   parameter bit SUPPORT_WIDE = 1'b1,
   localparam int ADDR_W = 2 * DATA_W,
   localparam int PL_W   = LEN_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_mode,
   input  logic [PTR_W-1:0]  tbl_start,
   input  logic [PTR_W-1:0]  tbl_end,
   input  logic [PTR_W-1:0]  tbl_wr,
   input  logic              ptr_load,
   input  logic [PTR_W-1:0]  ptr_val,
   input  logic              fetch_cmd,
   input  logic [CNT_W-1:0]  eob_words,
   input  logic              frm_valid,
   input  logic [LEN_W-1:0]  frm_len,
   output logic              mem_rd_req,
   output logic [PTR_W-1:0]  mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [CNT_W-1:0]  words_left,
   output logic [PTR_W-1:0]  rd_ptr,
   output logic              store_ok,
   output logic [ADDR_W-1:0] store_addr,
   output logic [PL_W-1:0]   store_len,
   output logic              frm_drop,
   output logic              irq_area_exceeded,
   output logic              irq_exhausted,
   output logic              blocked,
   output logic              busy,
   output logic [SEQ_W-1:0]  seq
);
   // elaboration-time parameter checks
   if (DATA_W != 16) begin : g_chk_data
      $error("DATA_W must be 16: table entries hold 16-bit words");
   end
   if (CNT_W != 2 * DATA_W) begin : g_chk_cnt
      $error("CNT_W must equal two table words");
   end
   if (PL_W > CNT_W + 1) begin : g_chk_len
      $error("LEN_W too wide for the word counter");
   end
   if (PTR_W < 6) begin : g_chk_ptr
      $error("PTR_W too narrow for a table");
   end
   if ((SEQ_W % 2) != 0 || SEQ_W < 4) begin : g_chk_seq
      $error("SEQ_W must be even and at least 4");
   end

   logic wide_eff;
   if (SUPPORT_WIDE) begin : g_wide
      assign wide_eff = wide_mode;
   end else begin : g_narrow_only
      assign wide_eff = 1'b0;
   end

   logic [PL_W-1:0]   padded;
   logic              fits;
   logic              accept;
   logic              take;
   logic              too_big;
   logic [CNT_W-1:0]  left_after;
   logic              last_frame;
   logic              rd_eq_wr;
   logic              go_block;
   logic              auto_fetch;
   logic              start_fetch;
   logic              ld_valid;
   logic [1:0]        ld_idx;
   logic [DATA_W-1:0] ld_data;
   logic              fetch_done;

   rbm_len_calc #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_len (
      .frm_len    (frm_len),
      .wide       (wide_eff),
      .words_left (words_left),
      .padded     (padded),
      .fits       (fits)
   );

   assign accept      = frm_valid && !busy && !blocked;
   assign take        = accept && fits;
   assign too_big     = accept && !fits;
   assign left_after  = words_left - CNT_W'(padded >> 1);
   assign last_frame  = too_big || (take && (left_after < eob_words));
   assign rd_eq_wr    = (rd_ptr == tbl_wr);
   assign go_block    = last_frame && rd_eq_wr;
   assign auto_fetch  = last_frame && !rd_eq_wr;
   assign start_fetch = auto_fetch || (fetch_cmd && !busy);

   rbm_fetch #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_fetch (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start_fetch),
      .wide         (wide_eff),
      .ptr_load     (ptr_load),
      .ptr_val      (ptr_val),
      .tbl_start    (tbl_start),
      .tbl_end      (tbl_end),
      .tbl_wr       (tbl_wr),
      .mem_rd_req   (mem_rd_req),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rd_valid (mem_rd_valid),
      .mem_rd_data  (mem_rd_data),
      .ld_valid     (ld_valid),
      .ld_idx       (ld_idx),
      .ld_data      (ld_data),
      .done         (fetch_done),
      .busy         (busy),
      .rd_ptr       (rd_ptr),
      .exhausted    (irq_exhausted)
   );

   rbm_account #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PL_W(PL_W), .SEQ_W(SEQ_W)) u_acct (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_valid   (ld_valid),
      .ld_idx     (ld_idx),
      .ld_data    (ld_data),
      .take       (take),
      .padded     (padded),
      .buf_addr   (buf_addr),
      .words_left (words_left),
      .seq        (seq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_ok          <= 1'b0;
         store_addr        <= '0;
         store_len         <= '0;
         frm_drop          <= 1'b0;
         irq_area_exceeded <= 1'b0;
         blocked           <= 1'b0;
      end else begin
         store_ok          <= take;
         frm_drop          <= frm_valid && (busy || blocked);
         irq_area_exceeded <= too_big;
         if (take) begin
            store_addr <= buf_addr;
            store_len  <= padded;
         end
         if (fetch_done) begin
            blocked <= 1'b0;
         end else if (go_block) begin
            blocked <= 1'b1;
         end
      end
   end

   AST_PAD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      store_ok |-> !store_len[0]);   // R1
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({store_ok, frm_drop, irq_area_exceeded}));   // R2
   AST_REFUSE_ENDS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
      irq_area_exceeded |-> (blocked || busy));   // R7
   AST_BLOCK_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |=> !store_ok);   // R8
   AST_BUSY_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !store_ok);   // R10
endmodule

// File: tb/rx_buf_rsrc_mgr_tb.sv
module rx_buf_rsrc_mgr_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_mode = 1'b0;
   logic [15:0] tbl_start = '0, tbl_end = '0, tbl_wr = '0, ptr_val = '0;
   logic        ptr_load = 1'b0, fetch_cmd = 1'b0, frm_valid = 1'b0;
   logic [31:0] eob_words = '0;
   logic [15:0] frm_len = '0;
   logic        mem_rd_req;
   logic [15:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [15:0] mem_rd_data = '0;
   logic [31:0] buf_addr, words_left, store_addr;
   logic [15:0] rd_ptr, seq;
   logic        store_ok, frm_drop, irq_area_exceeded, irq_exhausted, blocked, busy;
   logic [17:0] store_len;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   rx_buf_rsrc_mgr u_dut (
      .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
      .tbl_start(tbl_start), .tbl_end(tbl_end), .tbl_wr(tbl_wr),
      .ptr_load(ptr_load), .ptr_val(ptr_val), .fetch_cmd(fetch_cmd),
      .eob_words(eob_words), .frm_valid(frm_valid), .frm_len(frm_len),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .buf_addr(buf_addr), .words_left(words_left), .rd_ptr(rd_ptr),
      .store_ok(store_ok), .store_addr(store_addr), .store_len(store_len),
      .frm_drop(frm_drop), .irq_area_exceeded(irq_area_exceeded),
      .irq_exhausted(irq_exhausted), .blocked(blocked), .busy(busy), .seq(seq)
   );

   // table memory model: data two cycles after a request
   logic [15:0] mem [0:511];
   logic        rsp_pend = 1'b0;
   logic [15:0] rsp_addr = '0;
   logic [15:0] req_log [0:15];
   int          nreq = 0;
   int          exh_cnt = 0;

   always @(posedge clk) begin
      rsp_pend     <= mem_rd_req;
      rsp_addr     <= mem_rd_addr;
      mem_rd_valid <= rsp_pend;
      mem_rd_data  <= mem[rsp_addr[8:0]];
      if (mem_rd_req) begin
         req_log[nreq[3:0]] <= mem_rd_addr;
         nreq <= nreq + 1;
      end
      if (irq_exhausted) exh_cnt <= exh_cnt + 1;
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put_entry(input int ptr, input int step, input logic [31:0] a, input logic [31:0] c);
      mem[ptr]          = a[15:0];
      mem[ptr + step]   = a[31:16];
      mem[ptr + 2*step] = c[15:0];
      mem[ptr + 3*step] = c[31:16];
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200; i++) begin
         if (!busy) break;
         @(negedge clk);
      end
      check("R4 fetch completes", {63'd0, busy}, 64'd0);
      @(negedge clk);
   endtask

   task automatic do_fetch();
      @(negedge clk); fetch_cmd = 1'b1;
      @(negedge clk); fetch_cmd = 1'b0;
      wait_idle();
   endtask

   task automatic load_ptr(input logic [15:0] v);
      @(negedge clk); ptr_load = 1'b1; ptr_val = v;
      @(negedge clk); ptr_load = 1'b0;
   endtask

   task automatic send_frame(input int len);
      @(negedge clk); frm_valid = 1'b1; frm_len = 16'(len);
      @(negedge clk); frm_valid = 1'b0;
   endtask

   logic [31:0] exp_addr, exp_words;
   int          stored = 0;

   task automatic sweep(input bit wide, input int nlen);
      for (int l = 0; l < nlen; l++) begin
         int pad;
         pad = wide ? ((l + 4 + 3) / 4) * 4 : ((l + 4 + 1) / 2) * 2;
         send_frame(l);
         check("R3 store_ok", {63'd0, store_ok}, 64'd1);
         check("R1 padded length", 64'(store_len), 64'(pad));
         check("R3 store_addr", 64'(store_addr), 64'(exp_addr));
         exp_addr  = exp_addr + 32'(pad);
         exp_words = exp_words - 32'(pad / 2);
         check("R3 buf_addr", 64'(buf_addr), 64'(exp_addr));
         check("R3 words_left", 64'(words_left), 64'(exp_words));
         stored++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired (R4 fetch hang)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 512; i++) mem[i] = 16'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 buf_addr", 64'(buf_addr), 64'd0);
      check("R11 words_left", 64'(words_left), 64'd0);
      check("R11 rd_ptr", 64'(rd_ptr), 64'd0);
      check("R11 seq", 64'(seq), 64'd0);
      check("R11 blocked/busy", {62'd0, blocked, busy}, 64'd0);

      // narrow mode table
      wide_mode = 1'b0; tbl_start = 16'h100; tbl_end = 16'h118; tbl_wr = 16'h110;
      load_ptr(16'h101);
      check("R12 narrow align", 64'(rd_ptr), 64'h100);
      put_entry(16'h100, 2, 32'h1234_0010, 32'h0000_1000);
      nreq = 0;
      do_fetch();
      check("R4 req count", 64'(nreq), 64'd4);
      for (int k = 0; k < 4; k++) check("R4 narrow addr", 64'(req_log[k]), 64'(16'h100 + 2*k));
      check("R4 addr loaded", 64'(buf_addr), 64'h1234_0010);
      check("R4 count loaded", 64'(words_left), 64'h1000);
      check("R5 advance", 64'(rd_ptr), 64'h108);
      check("R6 no exhaust", 64'(exh_cnt), 64'd0);
      exp_addr = 32'h1234_0010; exp_words = 32'h1000;
      sweep(1'b0, 64);
      check("R9 seq after 64", 64'(seq), 64'd64);

      // wide mode table with wrap
      wide_mode = 1'b1; tbl_start = 16'h100; tbl_end = 16'h120; tbl_wr = 16'h100;
      load_ptr(16'h113);
      check("R12 wide align", 64'(rd_ptr), 64'h110);
      put_entry(16'h110, 4, 32'h0004_0000, 32'h0000_2000);
      nreq = 0;
      do_fetch();
      for (int k = 0; k < 4; k++) check("R4 wide addr", 64'(req_log[k]), 64'(16'h110 + 4*k));
      check("R5 wrap to start", 64'(rd_ptr), 64'h100);
      check("R6 exhaust pulse", 64'(exh_cnt), 64'd1);
      exp_addr = 32'h0004_0000; exp_words = 32'h2000;
      sweep(1'b1, 64);
      check("R9 seq after 128", 64'(seq), 64'h80);
      for (int i = 0; i < 130; i++) begin
         send_frame(0);
         stored++;
      end
      check("R9 seq wraps low byte", 64'(seq), 64'(stored % 256));
      check("R3 words after run", 64'(words_left), 64'(exp_words - 32'd260));

      // refused frame with no more entries -> blocked
      tbl_wr = 16'h110;
      put_entry(16'h100, 4, 32'h00A0_0000, 32'd5);
      do_fetch();
      check("R6 exhaust on equal", 64'(exh_cnt), 64'd2);
      send_frame(6);
      check("R2 area pulse", {62'd0, irq_area_exceeded, store_ok}, 64'b10);
      check("R2 addr unchanged", 64'(buf_addr), 64'h00A0_0000);
      check("R2 words unchanged", 64'(words_left), 64'd5);
      check("R7 blocked", {62'd0, blocked, busy}, 64'b10);
      send_frame(0);
      check("R8 drop while blocked", {62'd0, frm_drop, store_ok}, 64'b10);
      check("R8 state untouched", 64'(buf_addr), 64'h00A0_0000);
      tbl_wr = 16'h100;
      put_entry(16'h110, 4, 32'h00B0_0000, 32'd64);
      do_fetch();
      check("R8 unblocked", {63'd0, blocked}, 64'd0);
      check("R5 second wrap", 64'(rd_ptr), 64'h100);
      check("R6 third pulse", 64'(exh_cnt), 64'd3);

      // exact fit boundary
      send_frame(124);
      check("R2 exact fit stored", {63'd0, store_ok}, 64'd1);
      check("R2 words to zero", 64'(words_left), 64'd0);
      check("R7 no fetch at zero threshold", {63'd0, busy}, 64'd0);

      // low-space threshold triggers automatic fetch
      put_entry(16'h100, 4, 32'h00C0_0000, 32'd20);
      do_fetch();
      check("R6 no pulse", 64'(exh_cnt), 64'd3);
      put_entry(16'h110, 4, 32'h00D0_0000, 32'd50);
      eob_words = 32'd8;
      send_frame(20);
      check("R7 at threshold no fetch", {63'd0, busy}, 64'd0);
      check("R3 words 8", 64'(words_left), 64'd8);
      send_frame(0);
      check("R7 auto fetch", {62'd0, busy, blocked}, 64'b10);
      send_frame(8);
      check("R10 drop while busy", {62'd0, frm_drop, store_ok}, 64'b10);
      wait_idle();
      check("R7 new buffer", 64'(buf_addr), 64'h00D0_0000);
      check("R10 count intact", 64'(words_left), 64'd50);
      check("R6 fourth pulse", 64'(exh_cnt), 64'd4);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule